// File: doc/BRIEF.md
# Windowed CPU Address Decoder

This block steers each 32-bit CPU address to one of a set of programmable address windows. Every window holds a base field, a size mask and, where the window is remappable, a remap field. All three count in 64 KB pages, so they cover address bits [31:16]. A shared register holds one disable bit per window. The decoder compares the upper half of the address against every enabled window in parallel and resolves overlaps by fixed priority. One clock later it presents a one-hot target select, or a miss flag when no enabled window claims the address.

For remappable windows the block also produces an outbound address: the window start with the remap bits merged in under the size mask, plus the CPU offset inside the window. A flag marks outbound addresses that run past the end of the window. Software programs the windows through a single-cycle write port. A size value must be a run of ones from bit 0 upward and cover at least 1 MB. Any other size value is refused and latches an error flag that stays set until reset.

Top module: `addr_window_decoder`

## Requirements
- R1: During and after synchronous reset (active-high `rst`), `win_sel` is 0, `win_miss` is 0, `out_bad` is 0 and `size_err` is 0. Every window is disabled and every size field holds the 1 MB mask 0x000F.
- R2: When `cpu_valid` is high at a clock edge, `win_sel` bit i is high after that edge if window i is enabled and (cpu_addr[31:16] & ~size_i) == base_i. No other window of lower index may also match.
- R3: A write with `cfg_kind`=3 loads cfg_wdata[NUM_WIN-1:0] into the disable register. A set bit i keeps window i from matching, starting with the decode in the cycle after the write edge. A cleared bit enables the window.
- R4: When several enabled windows match, only the lowest-numbered one is selected, and `win_sel` is at most one-hot.
- R5: `win_miss` is high after an edge with `cpu_valid` high and no matching enabled window. When `cpu_valid` is low, both `win_sel` and `win_miss` are 0 after the edge.
- R6: A write with `cfg_kind`=1 sets the size field of window `cfg_idx` only if `cfg_wdata` is a contiguous run of ones from bit 0 with at least bits [3:0] set. Any other value leaves the field unchanged and sets the sticky `size_err`.
- R7: A base field with a bit set under that window's size mask never matches any address.
- R8: For a selected window whose bit in REMAP_EN (default 0xF0) is set, `out_addr` = ({base,16'h0} | ({remap,16'h0} & M)) + (cpu_addr & M), where M = {size,16'hFFFF}. `cfg_kind`=0 writes the base field and `cfg_kind`=2 writes the remap field.
- R9: `out_bad` is high when the 33-bit sum of R8 exceeds {base,16'h0} | M, including a carry out of bit 31. `out_addr` then carries the low 32 bits of the sum.
- R10: For a miss, or for a selected window outside REMAP_EN, `out_addr` equals the decoded `cpu_addr` and `out_bad` is 0. A remap write to such a window has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_valid | input | 1 | Address on `cpu_addr` is to be decoded |
| cpu_addr | input | 32 | CPU address |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | 0 base, 1 size, 2 remap, 3 disable bits |
| cfg_idx | input | 3 | Window addressed by the write |
| cfg_wdata | input | 16 | Field value in 64 KB pages, or disable bits |
| win_sel | output | 8 | One-hot selected window, registered |
| win_miss | output | 1 | No enabled window matched, registered |
| out_addr | output | 32 | Outbound address, registered |
| out_bad | output | 1 | Outbound address beyond window end |
| size_err | output | 1 | Sticky rejected-size flag |

## Verification
The decoder is driven with addresses deep inside a window and on the first and last byte of its span. These show whether the mask comparison is exact. Addresses one page past a window, addresses inside a disabled window and addresses against a misaligned base separate a true miss from a false hit. An address in a region where two windows overlap shows the priority order. On remappable windows, offsets that end exactly at the window top, one byte beyond it, and past bit 31 separate in-range results, overflow within the window and carry out of the address space. Non-contiguous and too-small size writes are followed by decodes that would only hit if the bad value had been stored.

// File: rtl/awd_pkg.sv
package awd_pkg;
    localparam int ADDR_W    = 32;
    localparam int PAGE_BITS = 16;
    localparam int FIELD_W   = ADDR_W - PAGE_BITS;

    typedef enum logic [1:0] {
        CFG_BASE    = 2'd0,
        CFG_SIZE    = 2'd1,
        CFG_REMAP   = 2'd2,
        CFG_DISABLE = 2'd3
    } cfg_kind_e;

    typedef struct packed {
        logic [FIELD_W-1:0] base;
        logic [FIELD_W-1:0] size;
        logic [FIELD_W-1:0] remap;
    } win_cfg_t;

    // A legal size mask is a run of ones from bit 0 covering at least min_log2 bits.
    function automatic logic mask_ok(input logic [FIELD_W-1:0] v, input int min_log2);
        logic [FIELD_W-1:0] low;
        low = (FIELD_W'(1) << min_log2) - FIELD_W'(1);
        return ((v & (v + FIELD_W'(1))) == '0) && ((v & low) == low);
    endfunction
endpackage

// File: rtl/awd_cfg_regs.sv
module awd_cfg_regs
    import awd_pkg::*;
#(
    parameter int                  NUM_WIN  = 8,
    parameter int                  MIN_LOG2 = 4,
    parameter logic [NUM_WIN-1:0]  REMAP_EN = 8'hF0,
    localparam int                 IDX_W    = $clog2(NUM_WIN)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cfg_we,
    input  cfg_kind_e                    cfg_kind,
    input  logic [IDX_W-1:0]             cfg_idx,
    input  logic [FIELD_W-1:0]           cfg_wdata,
    output win_cfg_t [NUM_WIN-1:0]       cfg_q,
    output logic [NUM_WIN-1:0]           dis_q,
    output logic                         size_err_q
);
    localparam logic [FIELD_W-1:0] RST_SIZE = (FIELD_W'(1) << MIN_LOG2) - FIELD_W'(1);

    logic size_legal;
    assign size_legal = mask_ok(cfg_wdata, MIN_LOG2);

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        win_cfg_t r;
        logic     hit_wr;
        assign hit_wr = cfg_we && (cfg_idx == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                r <= '{base: '0, size: RST_SIZE, remap: '0};
            end else if (hit_wr) begin
                unique case (cfg_kind)
                    CFG_BASE:    r.base <= cfg_wdata;
                    CFG_SIZE:    if (size_legal) r.size <= cfg_wdata;
                    CFG_REMAP:   if (REMAP_EN[i]) r.remap <= cfg_wdata;
                    CFG_DISABLE: ;
                    default:     ;
                endcase
            end
        end
        assign cfg_q[i] = r;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dis_q      <= '1;
            size_err_q <= 1'b0;
        end else if (cfg_we) begin
            if (cfg_kind == CFG_DISABLE) dis_q <= cfg_wdata[NUM_WIN-1:0];
            if (cfg_kind == CFG_SIZE && !size_legal) size_err_q <= 1'b1;
        end
    end
endmodule

// File: rtl/awd_window_match.sv
module awd_window_match
    import awd_pkg::*;
(
    input  logic [FIELD_W-1:0] addr_hi,
    input  logic [FIELD_W-1:0] base,
    input  logic [FIELD_W-1:0] size,
    input  logic               disabled,
    output logic               hit
);
    // Bits under the size mask are the in-window offset; the rest must equal base.
    assign hit = !disabled && ((addr_hi & ~size) == base);
endmodule

// File: rtl/awd_select.sv
module awd_select
    import awd_pkg::*;
#(
    parameter int                 NUM_WIN  = 8,
    parameter logic [NUM_WIN-1:0] REMAP_EN = 8'hF0,
    localparam int                IDX_W    = $clog2(NUM_WIN)
) (
    input  logic [NUM_WIN-1:0]     hit,
    input  win_cfg_t [NUM_WIN-1:0] cfg,
    input  logic [ADDR_W-1:0]      addr,
    output logic [NUM_WIN-1:0]     pick,
    output logic                   found,
    output logic [ADDR_W-1:0]      next_out,
    output logic                   next_bad
);
    logic [IDX_W-1:0]  idx;
    win_cfg_t          w;
    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] start;
    logic [ADDR_W:0]   sum;
    logic [ADDR_W:0]   limit;

    // Fixed priority: the lowest index among the hits wins.
    always_comb begin
        pick  = '0;
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (hit[i] && !found) begin
                found   = 1'b1;
                pick[i] = 1'b1;
                idx     = IDX_W'(i);
            end
        end
    end

    always_comb begin
        w     = cfg[idx];
        mask  = {w.size, {PAGE_BITS{1'b1}}};
        start = {w.base, {PAGE_BITS{1'b0}}} | ({w.remap, {PAGE_BITS{1'b0}}} & mask);
        sum   = {1'b0, start} + {1'b0, addr & mask};
        limit = {1'b0, {w.base, {PAGE_BITS{1'b0}}} | mask};
        if (found && REMAP_EN[idx]) begin
            next_out = sum[ADDR_W-1:0];
            next_bad = sum > limit;
        end else begin
            next_out = addr;
            next_bad = 1'b0;
        end
    end
endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
    import awd_pkg::*;
#(
    parameter int                 NUM_WIN  = 8,
    parameter int                 MIN_LOG2 = 4,
    parameter logic [NUM_WIN-1:0] REMAP_EN = 8'hF0,
    localparam int                IDX_W    = $clog2(NUM_WIN)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cpu_valid,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_kind,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [FIELD_W-1:0] cfg_wdata,
    output logic [NUM_WIN-1:0] win_sel,
    output logic               win_miss,
    output logic [ADDR_W-1:0]  out_addr,
    output logic               out_bad,
    output logic               size_err
);
    win_cfg_t [NUM_WIN-1:0] cfg;
    logic [NUM_WIN-1:0]     dis_bits;
    logic [NUM_WIN-1:0]     hits;
    logic [NUM_WIN-1:0]     pick;
    logic                   found;
    logic [ADDR_W-1:0]      next_out;
    logic                   next_bad;

    awd_cfg_regs #(
        .NUM_WIN  (NUM_WIN),
        .MIN_LOG2 (MIN_LOG2),
        .REMAP_EN (REMAP_EN)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_kind   (cfg_kind_e'(cfg_kind)),
        .cfg_idx    (cfg_idx),
        .cfg_wdata  (cfg_wdata),
        .cfg_q      (cfg),
        .dis_q      (dis_bits),
        .size_err_q (size_err)
    );

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_match
        awd_window_match u_match (
            .addr_hi  (cpu_addr[ADDR_W-1:PAGE_BITS]),
            .base     (cfg[i].base),
            .size     (cfg[i].size),
            .disabled (dis_bits[i]),
            .hit      (hits[i])
        );
    end

    awd_select #(
        .NUM_WIN  (NUM_WIN),
        .REMAP_EN (REMAP_EN)
    ) u_sel (
        .hit      (hits),
        .cfg      (cfg),
        .addr     (cpu_addr),
        .pick     (pick),
        .found    (found),
        .next_out (next_out),
        .next_bad (next_bad)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            win_sel  <= '0;
            win_miss <= 1'b0;
            out_addr <= '0;
            out_bad  <= 1'b0;
        end else begin
            win_sel  <= cpu_valid ? pick : '0;
            win_miss <= cpu_valid && !found;
            out_addr <= next_out;
            out_bad  <= cpu_valid && next_bad;
        end
    end
endmodule

// File: rtl/awd_checker.sv
module awd_checker
    import awd_pkg::*;
#(
    parameter int                 NUM_WIN  = 8,
    parameter int                 MIN_LOG2 = 4,
    parameter logic [NUM_WIN-1:0] REMAP_EN = 8'hF0
) (
    input logic               clk,
    input logic               rst,
    input logic               cpu_valid,
    input logic [ADDR_W-1:0]  cpu_addr,
    input logic               cfg_we,
    input logic [1:0]         cfg_kind,
    input logic [FIELD_W-1:0] cfg_wdata,
    input logic [NUM_WIN-1:0] win_sel,
    input logic               win_miss,
    input logic [ADDR_W-1:0]  out_addr,
    input logic               out_bad,
    input logic               size_err,
    input logic [NUM_WIN-1:0] dis_bits
);
    p_sel_onehot_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(win_sel));

    p_miss_no_sel_r5: assert property (@(posedge clk) disable iff (rst)
        win_miss |-> (win_sel == '0));

    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        !cpu_valid |=> (win_sel == '0 && !win_miss));

    p_disabled_silent_r3: assert property (@(posedge clk) disable iff (rst)
        cpu_valid |=> ((win_sel & $past(dis_bits)) == '0));

    p_err_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        size_err |=> size_err);

    p_reject_flags_r6: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_kind == 2'd1 && !mask_ok(cfg_wdata, MIN_LOG2)) |=> size_err);

    p_bad_needs_remap_r9: assert property (@(posedge clk) disable iff (rst)
        out_bad |-> ((win_sel & REMAP_EN) != '0));

    p_passthru_r10: assert property (@(posedge clk) disable iff (rst)
        cpu_valid |=> (((win_sel & REMAP_EN) == '0) -> (out_addr == $past(cpu_addr))));
endmodule

bind addr_window_decoder awd_checker #(
    .NUM_WIN  (NUM_WIN),
    .MIN_LOG2 (MIN_LOG2),
    .REMAP_EN (REMAP_EN)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_valid (cpu_valid),
    .cpu_addr  (cpu_addr),
    .cfg_we    (cfg_we),
    .cfg_kind  (cfg_kind),
    .cfg_wdata (cfg_wdata),
    .win_sel   (win_sel),
    .win_miss  (win_miss),
    .out_addr  (out_addr),
    .out_bad   (out_bad),
    .size_err  (size_err),
    .dis_bits  (dis_bits)
);

// File: tb/tb_addr_window_decoder.sv
`timescale 1ns/1ps
module tb_addr_window_decoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_valid = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_kind = '0;
    logic [2:0]  cfg_idx = '0;
    logic [15:0] cfg_wdata = '0;
    logic [7:0]  win_sel;
    logic        win_miss;
    logic [31:0] out_addr;
    logic        out_bad;
    logic        size_err;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    addr_window_decoder dut (
        .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_addr(cpu_addr),
        .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .win_sel(win_sel), .win_miss(win_miss), .out_addr(out_addr),
        .out_bad(out_bad), .size_err(size_err)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic [7:0]  sel;
        logic        miss;
        logic [31:0] out;
        logic        bad;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{32'h00123456, 8'h01, 1'b0, 32'h00123456, 1'b0}, // R2 interior
        '{32'h00850000, 8'h01, 1'b0, 32'h00850000, 1'b0}, // R4 overlap, W0 wins
        '{32'h00FFFFFF, 8'h01, 1'b0, 32'h00FFFFFF, 1'b0}, // R2 top byte
        '{32'h01000000, 8'h00, 1'b1, 32'h01000000, 1'b0}, // R5 one past W0
        '{32'h103FFFFF, 8'h04, 1'b0, 32'h103FFFFF, 1'b0}, // R2 top of W2
        '{32'h10400000, 8'h00, 1'b1, 32'h10400000, 1'b0}, // R5 past W2
        '{32'h20050000, 8'h00, 1'b1, 32'h20050000, 1'b0}, // R3 W3 disabled
        '{32'h40000010, 8'h10, 1'b0, 32'h40300010, 1'b0}, // R8 remap
        '{32'h40CFFFFF, 8'h10, 1'b0, 32'h40FFFFFF, 1'b0}, // R9 ends at top
        '{32'h40D00000, 8'h10, 1'b0, 32'h41000000, 1'b1}, // R9 one beyond
        '{32'h800BFFFF, 8'h20, 1'b0, 32'h800FFFFF, 1'b0}, // R8 remap masked bits
        '{32'h800C0000, 8'h20, 1'b0, 32'h80100000, 1'b1}, // R9 overflow
        '{32'h90010000, 8'h00, 1'b1, 32'h90010000, 1'b0}, // R7 misaligned base
        '{32'h90000000, 8'h00, 1'b1, 32'h90000000, 1'b0}, // R7 misaligned base
        '{32'hFFFFFFFF, 8'h00, 1'b1, 32'hFFFFFFFF, 1'b0}  // R5 top of space
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] kind, input logic [2:0] idx, input logic [15:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_kind = kind; cfg_idx = idx; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic probe(input logic [31:0] a);
        @(negedge clk);
        cpu_valid = 1'b1; cpu_addr = a;
        @(posedge clk);
        #1;
        cpu_valid = 1'b0;
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 sel at reset", 32'(win_sel), 32'h0);
        chk("R1 miss at reset", 32'(win_miss), 32'h0);
        chk("R1 err at reset", 32'(size_err), 32'h0);
        chk("R1 bad at reset", 32'(out_bad), 32'h0);
        @(negedge clk);
        rst = 1'b0;

        // R1: every window starts disabled, so even address 0 misses.
        probe(32'h00000000);
        chk("R1 all disabled sel", 32'(win_sel), 32'h0);
        chk("R1 all disabled miss", 32'(win_miss), 32'h1);

        // Configuration: kind 0 base, 1 size, 2 remap, 3 disable.
        cfg_write(2'd0, 3'd0, 16'h0000); cfg_write(2'd1, 3'd0, 16'h00FF);
        cfg_write(2'd0, 3'd1, 16'h0080); cfg_write(2'd1, 3'd1, 16'h000F);
        cfg_write(2'd0, 3'd2, 16'h1000); cfg_write(2'd1, 3'd2, 16'h003F);
        cfg_write(2'd0, 3'd3, 16'h2000); cfg_write(2'd1, 3'd3, 16'h000F);
        cfg_write(2'd0, 3'd4, 16'h4000); cfg_write(2'd1, 3'd4, 16'h00FF);
        cfg_write(2'd2, 3'd4, 16'h0030);
        cfg_write(2'd0, 3'd5, 16'h8000); cfg_write(2'd1, 3'd5, 16'h000F);
        cfg_write(2'd2, 3'd5, 16'h1234);
        cfg_write(2'd0, 3'd6, 16'h9001); cfg_write(2'd1, 3'd6, 16'h000F);
        cfg_write(2'd3, 3'd0, 16'h0088);
        #1;
        chk("R6 legal sizes keep err low", 32'(size_err), 32'h0);

        for (int k = 0; k < NV; k++) begin
            probe(VECS[k].addr);
            chk($sformatf("R2 vec%0d sel", k), 32'(win_sel), 32'(VECS[k].sel));
            chk($sformatf("R5 vec%0d miss", k), 32'(win_miss), 32'(VECS[k].miss));
            chk($sformatf("R8 vec%0d out", k), out_addr, VECS[k].out);
            chk($sformatf("R9 vec%0d bad", k), 32'(out_bad), 32'(VECS[k].bad));
        end

        // R5: valid low yields neither select nor miss.
        @(negedge clk);
        cpu_valid = 1'b0; cpu_addr = 32'h00123456;
        @(posedge clk); #1;
        chk("R5 idle sel", 32'(win_sel), 32'h0);
        chk("R5 idle miss", 32'(win_miss), 32'h0);

        // R6: non-contiguous size is refused.
        cfg_write(2'd1, 3'd2, 16'h0013);
        chk("R6 err after bad size", 32'(size_err), 32'h1);
        probe(32'h103FFFFF);
        chk("R6 old size kept", 32'(win_sel), 32'h04);
        // R6: contiguous but below 1 MB is refused.
        cfg_write(2'd1, 3'd2, 16'h0007);
        probe(32'h103FFFFF);
        chk("R6 small size refused", 32'(win_sel), 32'h04);
        chk("R6 err stays set", 32'(size_err), 32'h1);
        cfg_write(2'd1, 3'd2, 16'h00FF);
        probe(32'h10FF0000);
        chk("R6 larger size accepted", 32'(win_sel), 32'h04);

        // R3 and R4: disabling W0 exposes W1.
        cfg_write(2'd3, 3'd0, 16'h0089);
        probe(32'h00850000);
        chk("R4 W1 behind disabled W0", 32'(win_sel), 32'h02);
        probe(32'h00950000);
        chk("R3 W0 disabled miss", 32'(win_miss), 32'h1);

        // R10: remap write to a non-remappable window has no effect.
        cfg_write(2'd2, 3'd1, 16'hFFFF);
        probe(32'h00850000);
        chk("R10 passthrough addr", out_addr, 32'h00850000);
        chk("R10 passthrough bad", 32'(out_bad), 32'h0);

        // R3: re-enable everything.
        cfg_write(2'd3, 3'd0, 16'h0000);
        probe(32'h20050000);
        chk("R3 W3 enabled", 32'(win_sel), 32'h08);

        // R9: carry out of bit 31.
        cfg_write(2'd0, 3'd7, 16'hFF00); cfg_write(2'd1, 3'd7, 16'h00FF);
        cfg_write(2'd2, 3'd7, 16'h00F0);
        probe(32'hFF200000);
        chk("R9 carry sel", 32'(win_sel), 32'h80);
        chk("R9 carry out", out_addr, 32'h00100000);
        chk("R9 carry bad", 32'(out_bad), 32'h1);

        finish_run();
    end
endmodule